// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a general-purpose I/O peripheral for up to 32 pins, driven from a simple 32-bit register bus. Software picks a direction for each pin and sets the level of the output pins. It reads back the level of every pin and sets up an interrupt detector for each pin. Incoming pin levels pass through a two-flop synchronizer before any logic uses them.

Each pin's detector is either edge-triggered or level-triggered. One polarity register serves both modes, and its meaning depends on the mode. For a level-triggered pin a polarity of 1 selects active-high and 0 selects active-low. For an edge-triggered pin a polarity of 1 selects the falling edge and 0 selects the rising edge. Detected events collect in a sticky status register whether or not the pin is enabled. The pending view is status masked by the enable register. The single interrupt output is the OR of the pending bits. Software acknowledges an event by writing ones to a separate clear register.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset:
  - all pins are inputs (direction reads all ones);
  - the output register is zero;
  - enable is zero and status is zero;
  - every pin is in edge mode (mode register reads all ones);
  - polarity is zero;
  - `irq` is low.
- R2: Direction bit 1 makes the pin an input (`pin_oe` bit 0). Direction bit 0 makes it an output: `pin_oe` bit 1, and `pin_out` carries the written output bit.
- R3: Reading the level register (byte offset 0x00) returns:
  - for an input pin, its synchronized pin level;
  - for an output pin, its output register bit.
- R4: A pin with mode bit 0 (register 0x18) is level-triggered. With polarity bit 1 (register 0x1C) it records an event on every cycle it is high. With polarity 0 it records an event on every cycle it is low.
- R5: A pin with mode bit 1 is edge-triggered: polarity 0 records one event per rising transition, polarity 1 one event per falling transition, and the opposite transition records nothing.
- R6: Status (0x0C) is sticky and records events for every pin regardless of enable (0x08). Pending (0x10) reads status AND enable. `irq` is high exactly when some pending bit is set.
- R7: Writing 1 to a bit of the clear register (0x14) clears that status bit. Writing 0 leaves it unchanged. Writes to the status and pending registers have no effect.
- R8: A level-triggered pin whose active level is still present reads as set after a clear write.
- R9: When a new event and a clear write for the same pin fall on the same clock edge, the status bit stays set.
- R10: The following all read as zero:
  - offsets 0x20 and above, and the clear register;
  - unaligned addresses;
  - register bits at and above NPINS;
  - `bus_rdata` whenever `bus_re` is low.
- R11: A pin change sampled at clock edge k shows in the level read after edge k+1 and sets status at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_re` |
| pin_in | input | NPINS | Asynchronous pin levels from the pads |
| pin_out | output | NPINS | Output levels to the pads |
| pin_oe | output | NPINS | Output enable per pin (1 = driven) |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the race in R9, where a fresh edge and the acknowledging write meet at one clock edge. From the ports this needs exact knowledge of the synchronizer depth. The pin is first made pending, then returned to its idle level, and then toggled again. The clear write is placed on the second negative edge after that toggle, so the detector's event and the clear meet at the same rising edge. The level-persistence case (R8) is reached by holding the active level across the clear write and reading status back at once.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int DATA_W = 32;

    // Word index of each register (byte offset / 4); software depends on these.
    typedef enum logic [3:0] {
        SEL_LEVEL = 4'd0,
        SEL_DIR   = 4'd1,
        SEL_IEN   = 4'd2,
        SEL_ISTAT = 4'd3,
        SEL_IPEND = 4'd4,
        SEL_ICLR  = 4'd5,
        SEL_MODE  = 4'd6,
        SEL_POL   = 4'd7,
        SEL_NONE  = 4'd15
    } reg_sel_e;

    typedef struct packed {
        logic edge_mode;  // 1: edge, 0: level
        logic polarity;   // level: 1 high-active; edge: 1 falling
    } trig_cfg_t;

    function automatic reg_sel_e decode_addr(input logic [29:0] widx, input logic [1:0] lsb);
        reg_sel_e sel;
        sel = SEL_NONE;
        if (lsb == 2'b00) begin
            case (widx)
                30'd0:   sel = SEL_LEVEL;
                30'd1:   sel = SEL_DIR;
                30'd2:   sel = SEL_IEN;
                30'd3:   sel = SEL_ISTAT;
                30'd4:   sel = SEL_IPEND;
                30'd5:   sel = SEL_ICLR;
                30'd6:   sel = SEL_MODE;
                30'd7:   sel = SEL_POL;
                default: sel = SEL_NONE;
            endcase
        end
        return sel;
    endfunction

    function automatic logic trig_event(input trig_cfg_t cfg, input logic cur, input logic prev);
        logic hit;
        if (cfg.edge_mode)
            hit = cfg.polarity ? (prev & ~cur) : (cur & ~prev);
        else
            hit = (cur == cfg.polarity);
        return hit;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] level,
    input  logic [NPINS-1:0] mode,
    input  logic [NPINS-1:0] pol,
    output logic [NPINS-1:0] evt
);
    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        trig_cfg_t cfg;
        assign cfg.edge_mode = mode[i];
        assign cfg.polarity  = pol[i];
        assign evt[i] = trig_event(cfg, level[i], prev_q[i]);
    end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  level,
    input  logic [NPINS-1:0]  evt,
    output logic [NPINS-1:0]  out_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  en_q,
    output logic [NPINS-1:0]  mode_q,
    output logic [NPINS-1:0]  pol_q,
    output logic [NPINS-1:0]  stat_q
);
    reg_sel_e         sel;
    logic [NPINS-1:0] wbits;
    logic [NPINS-1:0] clr_mask;
    logic [NPINS-1:0] pick;

    assign sel      = decode_addr(30'(bus_addr[ADDR_W-1:2]), bus_addr[1:0]);
    assign wbits    = bus_wdata[NPINS-1:0];
    assign clr_mask = (bus_we && sel == SEL_ICLR) ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= '1;
            en_q   <= '0;
            mode_q <= '1;
            pol_q  <= '0;
            stat_q <= '0;
        end else begin
            if (bus_we) begin
                case (sel)
                    SEL_LEVEL: out_q  <= wbits;
                    SEL_DIR:   dir_q  <= wbits;
                    SEL_IEN:   en_q   <= wbits;
                    SEL_MODE:  mode_q <= wbits;
                    SEL_POL:   pol_q  <= wbits;
                    default:   ;
                endcase
            end
            // a fresh event outranks a clear in the same cycle
            stat_q <= evt | (stat_q & ~clr_mask);
        end
    end

    always_comb begin
        pick = '0;
        if (bus_re) begin
            case (sel)
                SEL_LEVEL: pick = level;
                SEL_DIR:   pick = dir_q;
                SEL_IEN:   pick = en_q;
                SEL_ISTAT: pick = stat_q;
                SEL_IPEND: pick = stat_q & en_q;
                SEL_MODE:  pick = mode_q;
                SEL_POL:   pick = pol_q;
                default:   pick = '0;
            endcase
        end
        bus_rdata = '0;
        bus_rdata[NPINS-1:0] = pick;
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] sync_w;
    logic [NPINS-1:0] level_w;
    logic [NPINS-1:0] evt_w;
    logic [NPINS-1:0] out_w, dir_w, en_w, mode_w, pol_w, stat_w;

    gpio_irq_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(sync_w)
    );

    // inputs read from the synchronizer, outputs from their own driver bit
    assign level_w = (dir_w & sync_w) | (~dir_w & out_w);

    gpio_irq_detect #(.NPINS(NPINS)) u_detect (
        .clk(clk), .rst(rst), .level(level_w),
        .mode(mode_w), .pol(pol_w), .evt(evt_w)
    );

    gpio_irq_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_re(bus_re), .bus_rdata(bus_rdata),
        .level(level_w), .evt(evt_w),
        .out_q(out_w), .dir_q(dir_w), .en_q(en_w),
        .mode_q(mode_w), .pol_q(pol_w), .stat_q(stat_w)
    );

    assign pin_out = out_w;
    assign pin_oe  = ~dir_w;
    assign irq     = |(stat_w & en_w);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic [NPINS-1:0]  evt,
    input logic [NPINS-1:0]  stat,
    input logic [NPINS-1:0]  en
);
    localparam logic [31:0] MASK = (NPINS >= 32) ? 32'hFFFF_FFFF : ((32'd1 << NPINS) - 32'd1);

    logic [NPINS-1:0] clr;
    assign clr = (bus_we && bus_addr == ADDR_W'(8'h14)) ? bus_wdata[NPINS-1:0] : '0;

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq); // R6
    AST_EVENT_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat & $past(evt)) == $past(evt))); // R9
    AST_NO_PHANTOM_STATUS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat & ~$past(stat) & ~$past(evt)) == '0)); // R5
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat & $past(clr & ~evt)) == '0)); // R7
    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_re |-> (bus_rdata == 32'd0)); // R10
    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_re |-> ((bus_rdata & ~MASK) == 32'd0)); // R10
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .irq(irq), .evt(evt_w), .stat(stat_w), .en(en_w)
);

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
    localparam int NP = 12;
    localparam int AW = 6;
    localparam logic [5:0] A_LEVEL = 6'h00, A_DIR = 6'h04, A_IEN = 6'h08, A_ISTAT = 6'h0C,
                           A_IPEND = 6'h10, A_ICLR = 6'h14, A_MODE = 6'h18, A_POL = 6'h1C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_re = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(NP), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_now(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #0.5;
        d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] d;
        @(negedge clk);
        rd_now(a, d);
        chk(tag, d, exp);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic clean();
        settle();
        bus_write(A_ICLR, 32'hFFF);
    endtask

    task automatic t_reset();
        rd_chk("R1 dir", A_DIR, 32'hFFF);
        rd_chk("R1 level", A_LEVEL, 32'h0);
        rd_chk("R1 ien", A_IEN, 32'h0);
        rd_chk("R1 istat", A_ISTAT, 32'h0);
        rd_chk("R1 mode", A_MODE, 32'hFFF);
        rd_chk("R1 pol", A_POL, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 pin_oe", 32'(pin_oe), 32'h0);
    endtask

    task automatic t_dir_value();
        logic [31:0] d;
        bus_write(A_DIR, 32'hFF0);
        bus_write(A_LEVEL, 32'h00A);
        pin_in = 12'h0A5;  // low nibble ignored: those pins are outputs
        settle();
        chk("R2 pin_oe", 32'(pin_oe), 32'h00F);
        chk("R2 pin_out", 32'(pin_out), 32'h00A);
        rd_chk("R3 level mixed", A_LEVEL, 32'h0AA);
        @(negedge clk);
        pin_in[9] = 1'b1;
        @(negedge clk);
        rd_now(A_LEVEL, d);
        chk("R11 level after one edge", d, 32'h0AA);
        @(negedge clk);
        rd_now(A_LEVEL, d);
        chk("R11 level after two edges", d, 32'h2AA);
        bus_write(A_DIR, 32'hFFF);
        bus_write(A_LEVEL, 32'h0);
        pin_in = '0;
        clean();
        rd_chk("R7 all cleared", A_ISTAT, 32'h0);
    endtask

    task automatic t_edge_rise();
        logic [31:0] d;
        @(negedge clk);
        pin_in[4] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd_now(A_ISTAT, d);
        chk("R11 status not before edge k+2", d, 32'h0);
        @(negedge clk);
        rd_now(A_ISTAT, d);
        chk("R5 rising edge seen", d, 32'h010);
        settle();
        pin_in[4] = 1'b0;
        settle();
        rd_chk("R6 status sticky", A_ISTAT, 32'h010);
        bus_write(A_ICLR, 32'h010);
        settle();
        rd_chk("R5 fall ignored in rising mode", A_ISTAT, 32'h0);
    endtask

    task automatic t_edge_fall();
        bus_write(A_POL, 32'h010);
        pin_in[4] = 1'b1;
        settle();
        rd_chk("R5 rise ignored in falling mode", A_ISTAT, 32'h0);
        pin_in[4] = 1'b0;
        settle();
        rd_chk("R5 falling edge seen", A_ISTAT, 32'h010);
        bus_write(A_POL, 32'h0);
        clean();
    endtask

    task automatic t_level();
        bus_write(A_POL, 32'h040);
        bus_write(A_MODE, 32'hFBF);
        clean();
        rd_chk("R4 high-active idle", A_ISTAT, 32'h0);
        pin_in[6] = 1'b1;
        settle();
        rd_chk("R4 high level seen", A_ISTAT, 32'h040);
        bus_write(A_ICLR, 32'h040);
        rd_chk("R8 level persists over clear", A_ISTAT, 32'h040);
        pin_in[6] = 1'b0;
        clean();
        rd_chk("R4 cleared when inactive", A_ISTAT, 32'h0);
        bus_write(A_POL, 32'h0);
        settle();
        rd_chk("R4 low level seen", A_ISTAT, 32'h040);
        bus_write(A_MODE, 32'hFFF);
        clean();
        rd_chk("R5 back to edge mode quiet", A_ISTAT, 32'h0);
    endtask

    task automatic t_enable();
        pin_in[5] = 1'b1;
        settle();
        rd_chk("R6 raw status while disabled", A_ISTAT, 32'h020);
        rd_chk("R6 pending masked", A_IPEND, 32'h0);
        chk("R6 irq low while disabled", {31'd0, irq}, 32'd0);
        bus_write(A_IEN, 32'h020);
        rd_chk("R6 pending visible", A_IPEND, 32'h020);
        chk("R6 irq high", {31'd0, irq}, 32'd1);
        bus_write(A_ICLR, 32'h0);
        rd_chk("R7 zero clear no effect", A_ISTAT, 32'h020);
        bus_write(A_ISTAT, 32'h0);
        bus_write(A_IPEND, 32'h0);
        rd_chk("R7 status read-only", A_ISTAT, 32'h020);
        bus_write(A_ICLR, 32'h020);
        @(negedge clk);
        chk("R7 irq dropped after clear", {31'd0, irq}, 32'd0);
        rd_chk("R7 pending cleared", A_IPEND, 32'h0);
        pin_in[5] = 1'b0;
        bus_write(A_IEN, 32'h0);
        clean();
    endtask

    task automatic t_coincide();
        pin_in[8] = 1'b1;
        settle();
        rd_chk("R9 first event", A_ISTAT, 32'h100);
        pin_in[8] = 1'b0;
        settle();
        @(negedge clk);
        pin_in[8] = 1'b1;
        @(negedge clk);
        bus_write(A_ICLR, 32'h100);  // clear lands on the edge that records the new event
        rd_chk("R9 new event beats clear", A_ISTAT, 32'h100);
        bus_write(A_ICLR, 32'h100);
        rd_chk("R9 later clear works", A_ISTAT, 32'h0);
        pin_in[8] = 1'b0;
        clean();
    endtask

    task automatic t_readmap();
        logic [31:0] d;
        bus_write(A_IEN, 32'hFFFF_FFFF);
        rd_chk("R10 upper bits zero", A_IEN, 32'h0000_0FFF);
        rd_chk("R10 unused offset", 6'h24, 32'h0);
        rd_chk("R10 unaligned", 6'h09, 32'h0);
        rd_chk("R10 clear reads zero", A_ICLR, 32'h0);
        @(negedge clk);
        d = bus_rdata;
        chk("R10 idle rdata", d, 32'h0);
        chk("R6 irq low with empty status", {31'd0, irq}, 32'd0);
        bus_write(A_IEN, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_dir_value();
        t_edge_rise();
        t_edge_fall();
        t_level();
        t_enable();
        t_coincide();
        t_readmap();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule